// File: doc/BRIEF.md
# West-First Adaptive Mesh Route Selector

This block computes the output port for a packet arriving on one input of a two-dimensional mesh router. It takes the destination coordinates from the packet header and this node's own coordinates. From them it forms signed offsets for x and y, each equal to destination minus here. It then chooses one of five ports: west, east, south, north or the local processor.

The choice follows the west-first turn model. Any westward travel happens before any other move, and a packet that has stopped moving west never turns west again. This removes enough turns from the channel dependence graph to rule out deadlock. Unlike plain x-then-y ordering, it leaves a choice whenever the packet still needs to go east and also north or south.

Where that choice exists, per-direction congestion inputs steer the packet toward the quieter link. Per-direction failure inputs remove links from consideration altogether. If no legal productive link remains, the block raises an error flag instead of a request. The result is registered and appears one clock after the header is presented.

Top module: `wf_route_sel`

## Requirements
- R1: After reset, and in the cycle following any cycle with `hdr_valid` low, `req_valid`, `route_err` and `req_port` are all zero.
- R2: When the destination x is below the local x, the request one cycle later is west (`req_port` = 5'b00001). This holds whatever the y offset and the congestion inputs are, provided west is not failed.
- R3: When westward travel is needed and the west link is failed (`link_fail[0]`), `route_err` is raised and no request is made. No other direction is ever substituted.
- R4: When destination equals local coordinates in both axes, the request is local (`req_port` = 5'b10000), regardless of congestion and failure inputs.
- R5: With exactly one legal productive direction, it is requested. East is 5'b00010 (dst x above local x), south is 5'b00100 (x equal, dst y below local y) and north is 5'b01000 (x equal, dst y above local y). This holds even if that link is congested.
- R6: When east and one y direction are both productive and unfailed, and exactly one of them is congested (`link_busy` bits: 0 west, 1 east, 2 south, 3 north), the uncongested one is requested.
- R7: In the case of R6 where both or neither are congested, east is requested.
- R8: A direction whose `link_fail` bit (same bit order as `link_busy`) is set is never requested; if the other productive direction is unfailed it is taken.
- R9: When the packet is not at its destination and every productive direction is failed, `route_err` is raised, `req_valid` stays low and `req_port` is zero.
- R10: West is never requested when the destination x is at or above the local x.
- R11: `req_port` carries exactly one set bit while `req_valid` is high, and `route_err` and `req_valid` are never high together.
- R12: Coordinates are unsigned; offsets at the extremes (0 to 15 and 15 to 0 in either axis) route in the correct direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header coordinates are valid this cycle |
| dst_x | input | 4 | Destination x coordinate |
| dst_y | input | 4 | Destination y coordinate |
| loc_x | input | 4 | This node's x coordinate |
| loc_y | input | 4 | This node's y coordinate |
| link_busy | input | 4 | Congestion per direction: bit 0 west, 1 east, 2 south, 3 north |
| link_fail | input | 4 | Failed link per direction, same bit order |
| req_valid | output | 1 | A port request is issued |
| req_port | output | 5 | One-hot request: bit 0 west, 1 east, 2 south, 3 north, 4 local |
| route_err | output | 1 | No legal productive direction for the header |

## Verification
Every result, whether a request, an error or the cleared state, is due exactly one rising edge after the inputs that cause it. The bench changes inputs on the falling edge and computes the expected result from its own behavioural model at that moment. It compares the outputs at the next falling edge, after the single capturing rising edge, so each comparison pairs one stimulus with one response. Idle cycles are compared the same way, which checks that nothing lingers past the cycle it belongs to.

// File: rtl/wf_route_pkg.sv
package wf_route_pkg;

   localparam int unsigned DIR_W     = 0;
   localparam int unsigned DIR_E     = 1;
   localparam int unsigned DIR_S     = 2;
   localparam int unsigned DIR_N     = 3;
   localparam int unsigned PORT_LOC  = 4;
   localparam int unsigned NUM_LINKS = 4;
   localparam int unsigned NUM_PORTS = NUM_LINKS + 1;

   typedef logic [NUM_LINKS-1:0] link_vec_t;
   typedef logic [NUM_PORTS-1:0] port_vec_t;

   localparam port_vec_t PORT_NONE = '0;

endpackage

// File: rtl/wf_axis_offset.sv
module wf_axis_offset #(
   parameter int unsigned COORD_W = 4,
   localparam int unsigned OFF_W  = COORD_W + 1
) (
   input  logic [COORD_W-1:0]     dst_i,
   input  logic [COORD_W-1:0]     here_i,
   output logic signed [OFF_W-1:0] off_o
);

   always_comb begin
      off_o = $signed({1'b0, dst_i}) - $signed({1'b0, here_i});
   end

endmodule

// File: rtl/wf_productive.sv
module wf_productive
   import wf_route_pkg::*;
#(
   parameter int unsigned COORD_W = 4,
   localparam int unsigned OFF_W  = COORD_W + 1
) (
   input  logic signed [OFF_W-1:0] dx_i,
   input  logic signed [OFF_W-1:0] dy_i,
   output link_vec_t               prod_o,
   output logic                    at_dest_o
);

   logic go_west;

   always_comb begin
      go_west         = dx_i < 0;
      prod_o          = '0;
      // westward hops come first and exclude everything else
      prod_o[DIR_W]   = go_west;
      prod_o[DIR_E]   = !go_west && (dx_i > 0);
      prod_o[DIR_S]   = !go_west && (dy_i < 0);
      prod_o[DIR_N]   = !go_west && (dy_i > 0);
      at_dest_o       = (dx_i == '0) && (dy_i == '0);
   end

endmodule

// File: rtl/wf_port_pick.sv
module wf_port_pick
   import wf_route_pkg::*;
#(
   parameter bit TIE_PREF_EAST = 1'b1
) (
   input  link_vec_t cand_i,
   input  link_vec_t busy_i,
   output port_vec_t port_o,
   output logic      none_o
);

   logic      y_cand;
   logic      y_busy;
   logic      e_busy;
   logic      take_y;
   port_vec_t y_port;

   always_comb begin
      y_cand = cand_i[DIR_S] | cand_i[DIR_N];
      y_busy = (cand_i[DIR_S] & busy_i[DIR_S]) | (cand_i[DIR_N] & busy_i[DIR_N]);
      e_busy = busy_i[DIR_E];
      y_port = '0;
      y_port[DIR_S] = cand_i[DIR_S];
      y_port[DIR_N] = cand_i[DIR_N];
   end

   generate
      if (TIE_PREF_EAST) begin : g_tie_east
         always_comb take_y = e_busy && !y_busy;
      end else begin : g_tie_y
         always_comb take_y = !(y_busy && !e_busy);
      end
   endgenerate

   always_comb begin
      port_o = PORT_NONE;
      none_o = 1'b0;
      if (cand_i[DIR_W]) begin
         port_o[DIR_W] = 1'b1;
      end else if (cand_i[DIR_E] && y_cand) begin
         if (take_y) port_o = y_port;
         else        port_o[DIR_E] = 1'b1;
      end else if (cand_i[DIR_E]) begin
         port_o[DIR_E] = 1'b1;
      end else if (y_cand) begin
         port_o = y_port;
      end else begin
         none_o = 1'b1;
      end
   end

endmodule

// File: rtl/wf_route_sel.sv
module wf_route_sel
   import wf_route_pkg::*;
#(
   parameter int unsigned COORD_W       = 4,
   parameter bit          TIE_PREF_EAST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hdr_valid,
   input  logic [COORD_W-1:0] dst_x,
   input  logic [COORD_W-1:0] dst_y,
   input  logic [COORD_W-1:0] loc_x,
   input  logic [COORD_W-1:0] loc_y,
   input  logic [3:0]         link_busy,
   input  logic [3:0]         link_fail,
   output logic               req_valid,
   output logic [4:0]         req_port,
   output logic               route_err
);

   localparam int unsigned OFF_W  = COORD_W + 1;
   localparam int unsigned N_AXES = 2;

   generate
      if (COORD_W < 1 || COORD_W > 15) begin : g_bad_width
         $error("wf_route_sel: COORD_W out of range");
      end
   endgenerate

   logic [COORD_W-1:0]       dst_a  [N_AXES];
   logic [COORD_W-1:0]       here_a [N_AXES];
   logic signed [OFF_W-1:0]  off_a  [N_AXES];

   always_comb begin
      dst_a[0]  = dst_x;
      dst_a[1]  = dst_y;
      here_a[0] = loc_x;
      here_a[1] = loc_y;
   end

   generate
      for (genvar ax = 0; ax < N_AXES; ax++) begin : g_axis
         wf_axis_offset #(.COORD_W(COORD_W)) u_off (
            .dst_i  (dst_a[ax]),
            .here_i (here_a[ax]),
            .off_o  (off_a[ax])
         );
      end
   endgenerate

   link_vec_t prod;
   logic      at_dest;

   wf_productive #(.COORD_W(COORD_W)) u_prod (
      .dx_i      (off_a[0]),
      .dy_i      (off_a[1]),
      .prod_o    (prod),
      .at_dest_o (at_dest)
   );

   link_vec_t cand;
   port_vec_t pick_port;
   logic      pick_none;

   always_comb cand = prod & ~link_fail;

   wf_port_pick #(.TIE_PREF_EAST(TIE_PREF_EAST)) u_pick (
      .cand_i (cand),
      .busy_i (link_busy),
      .port_o (pick_port),
      .none_o (pick_none)
   );

   port_vec_t next_port;
   logic      next_err;

   always_comb begin
      if (at_dest) begin
         next_port           = PORT_NONE;
         next_port[PORT_LOC] = 1'b1;
         next_err            = 1'b0;
      end else begin
         next_port = pick_port;
         next_err  = pick_none;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         route_err <= 1'b0;
         req_port  <= PORT_NONE;
      end else begin
         req_valid <= hdr_valid && !next_err;
         route_err <= hdr_valid && next_err;
         req_port  <= (hdr_valid && !next_err) ? next_port : PORT_NONE;
      end
   end

endmodule

// File: rtl/wf_route_sel_chk.sv
module wf_route_sel_chk #(
   parameter int unsigned COORD_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               hdr_valid,
   input logic [COORD_W-1:0] dst_x,
   input logic [COORD_W-1:0] dst_y,
   input logic [COORD_W-1:0] loc_x,
   input logic [COORD_W-1:0] loc_y,
   input logic [3:0]         link_fail,
   input logic               req_valid,
   input logic [4:0]         req_port,
   input logic               route_err
);

   assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(hdr_valid) |-> (!req_valid && !route_err && req_port == 5'b0));

   assert_west_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && $past(dst_x) < $past(loc_x)) |-> req_port[0]);

   assert_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && $past(dst_x) == $past(loc_x) && $past(dst_y) == $past(loc_y))
      |-> req_port[4]);

   assert_fail_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ((req_port[3:0] & $past(link_fail)) == 4'b0));

   assert_no_west_turn_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dst_x) >= $past(loc_x)) |-> !req_port[0]);

   assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ($countones(req_port) == 1));

   assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && route_err));

   assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      route_err |-> (req_port == 5'b0));

endmodule

bind wf_route_sel wf_route_sel_chk #(.COORD_W(COORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hdr_valid (hdr_valid),
   .dst_x     (dst_x),
   .dst_y     (dst_y),
   .loc_x     (loc_x),
   .loc_y     (loc_y),
   .link_fail (link_fail),
   .req_valid (req_valid),
   .req_port  (req_port),
   .route_err (route_err)
);

// File: tb/wf_route_sel_tb_top.sv
module wf_route_sel_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hdr_valid = 1'b0;
   logic [3:0] dst_x = '0, dst_y = '0, loc_x = '0, loc_y = '0;
   logic [3:0] link_busy = '0, link_fail = '0;
   logic       req_valid;
   logic [4:0] req_port;
   logic       route_err;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic       exp_v, exp_e;
   logic [4:0] exp_p;

   always #(CLK_PERIOD/2) clk = ~clk;

   wf_route_sel dut_i (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid),
      .dst_x(dst_x), .dst_y(dst_y), .loc_x(loc_x), .loc_y(loc_y),
      .link_busy(link_busy), .link_fail(link_fail),
      .req_valid(req_valid), .req_port(req_port), .route_err(route_err)
   );

   // behavioural reference: returns port bit index, -1 for error
   function automatic int ref_route(int dx_, int dy_, int lx, int ly,
                                    logic [3:0] bz, logic [3:0] fl);
      int ox = dx_ - lx;
      int oy = dy_ - ly;
      int ydir;
      bit e_ok, y_ok;
      if (ox == 0 && oy == 0) return 4;
      if (ox < 0) return fl[0] ? -1 : 0;
      ydir = (oy < 0) ? 2 : 3;
      e_ok = (ox > 0) && !fl[1];
      y_ok = (oy != 0) && !fl[ydir];
      if (e_ok && y_ok) begin
         if (bz[1] && !bz[ydir]) return ydir;
         return 1;
      end
      if (e_ok) return 1;
      if (y_ok) return ydir;
      return -1;
   endfunction

   function automatic string tag_of(logic hv, int dx_, int dy_, int lx, int ly,
                                    logic [3:0] fl);
      int r;
      if (!hv) return "R1";
      r = ref_route(dx_, dy_, lx, ly, 4'b0, fl);
      if (dx_ < lx) return fl[0] ? "R3" : "R2";
      if (r == 4) return "R4";
      if (r < 0) return "R9";
      if (dx_ > lx && dy_ != ly) return "R6";
      return "R5";
   endfunction

   task automatic compare(string tag);
      checks++;
      if (req_valid !== exp_v || route_err !== exp_e || req_port !== exp_p) begin
         errors++;
         $display("FAIL %s: got v=%b e=%b port=%b, expected v=%b e=%b port=%b",
                  tag, req_valid, route_err, req_port, exp_v, exp_e, exp_p);
      end
   endtask

   // called at a falling edge; compares at the next falling edge
   task automatic step(string tag, logic hv, int dx_, int dy_, int lx, int ly,
                       logic [3:0] bz, logic [3:0] fl);
      int r;
      hdr_valid = hv;
      dst_x = 4'(dx_); dst_y = 4'(dy_); loc_x = 4'(lx); loc_y = 4'(ly);
      link_busy = bz; link_fail = fl;
      r = ref_route(dx_, dy_, lx, ly, bz, fl);
      exp_v = hv && (r >= 0);
      exp_e = hv && (r < 0);
      exp_p = exp_v ? (5'b1 << r) : 5'b0;
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      exp_v = 0; exp_e = 0; exp_p = 0;
      compare("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after release");

      // R2 west first, y and congestion irrelevant
      step("R2", 1, 2, 9, 7, 3, 4'b1111, 4'b1110);
      step("R2", 1, 0, 0, 5, 5, 4'b0001, 4'b0000);
      // R1 idle follows a request
      step("R1", 0, 2, 9, 7, 3, 4'b0000, 4'b0000);
      // R3 west failed, no substitution
      step("R3", 1, 1, 12, 6, 2, 4'b0000, 4'b0001);
      // R4 local, inputs ignored
      step("R4", 1, 8, 8, 8, 8, 4'b1111, 4'b1111);
      // R5 single direction, congested anyway
      step("R5", 1, 9, 4, 3, 4, 4'b0010, 4'b0000);
      step("R5", 1, 3, 1, 3, 6, 4'b0100, 4'b0000);
      step("R5", 1, 3, 14, 3, 6, 4'b1000, 4'b0000);
      // R6 pick uncongested
      step("R6", 1, 9, 9, 2, 2, 4'b0010, 4'b0000);
      step("R6", 1, 9, 1, 2, 5, 4'b0100, 4'b0000);
      // R7 ties prefer east
      step("R7", 1, 9, 9, 2, 2, 4'b1010, 4'b0000);
      step("R7", 1, 9, 1, 2, 5, 4'b0000, 4'b0000);
      // R8 failed direction masked, remaining taken even if busy
      step("R8", 1, 9, 9, 2, 2, 4'b1000, 4'b0010);
      step("R8", 1, 9, 1, 2, 5, 4'b0010, 4'b0100);
      // R9 nothing legal
      step("R9", 1, 9, 9, 2, 2, 4'b0000, 4'b1010);
      step("R9", 1, 3, 0, 3, 9, 4'b0000, 4'b0100);
      // R10 / R12 extremes
      step("R12", 1, 15, 0, 0, 15, 4'b0000, 4'b0000);
      step("R12", 1, 0, 15, 15, 0, 4'b0000, 4'b0000);
      step("R10", 1, 15, 15, 0, 0, 4'b0011, 4'b0000);
      step("R12", 1, 0, 15, 0, 0, 4'b0000, 4'b0000);
      step("R1", 0, 0, 0, 0, 0, 4'b0000, 4'b0000);

      // sweep, R11 covered by every comparison
      for (int i = 0; i < 3000; i++) begin
         logic       hv = ($urandom % 8) != 0;
         int         a = $urandom % 16, b = $urandom % 16;
         int         c = $urandom % 16, d = $urandom % 16;
         logic [3:0] bz = 4'($urandom);
         logic [3:0] fl = (($urandom % 3) == 0) ? 4'($urandom) : 4'b0;
         if (($urandom % 6) == 0) c = a;
         if (($urandom % 6) == 0) d = b;
         step(tag_of(hv, a, b, c, d, fl), hv, a, b, c, d, bz, fl);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule